// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Single-Source Elevation

The block decides which interrupt source a CPU should service next and presents that choice as a request line, an 8-bit vector low byte and a numeric source identifier. It weighs six non-maskable sources and a numbered set of maskable sources. The maskable set is the external request pin plus `NMASK-1` peripheral sources, each of which asks for service through its own flag and enable bits. The CPU mask bits act as gates. The I bit blocks every maskable source. The X bit blocks only the external non-maskable pin.

A small write port holds two settings. The first is an elevation byte: writing the vector low byte of one maskable source lifts that source above every other maskable source. This write is accepted only while the I bit is set. The second is a single mode bit that makes the external maskable pin either falling-edge or low-level sensitive. An edge is remembered until the CPU acknowledges service of that source.

The choice is registered. While the request line is high and no acknowledge arrives, the output holds. When the output is idle or acknowledged, it loads the current winner at the next clock.

Top module: `intprio_ctrl`

## Requirements
- R1: After synchronous reset, `int_req`, `vec_lo` and `src_id` are all zero. The elevation byte reads as 0xDE, which elevates maskable source 10. The pin mode is low-level.
- R2: The non-maskable sources are ranked from highest to lowest with these identifiers and vectors: power-on reset (id 0, 0xFE), clock monitor (id 1, 0xFC), watchdog (id 2, 0xFA), external pin `xirq_n` (id 3, 0xF4), opcode trap (id 4, 0xF8), software interrupt (id 5, 0xF6).
- R3: Maskable source k has id 6+k and vector 0xF2−2k. Source 0 is the `irq_n` pin. Source k≥1 requests only when both `periph_flag[k-1]` and `periph_en[k-1]` are 1. Among requesting sources, the lowest k wins. None of them is granted while `i_bit` is 1.
- R4: The `xirq_n` source requests while the pin is low and `x_bit` is 0. It outranks every maskable source and is ignored while `x_bit` is 1.
- R5: The trap and software-interrupt sources are granted only when no reset source, no `xirq_n` source and no unmasked maskable source is requesting.
- R6: When the elevation byte equals the vector of maskable source e, a requesting source e beats every other maskable source.
- R7: A write with `wr_sel`=0 sets the elevation byte to `{wr_data[7:1],0}`, but only in a cycle where `i_bit` is 1. Otherwise the byte is unchanged.
- R8: An elevation byte that matches no maskable vector leaves the default order in force.
- R9: A write with `wr_sel`=1 sets the pin mode from `wr_data[0]`. A value of 1 means a falling edge of `irq_n` is latched until it is acknowledged. A value of 0 means `irq_n` requests while it is low.
- R10: The outputs change only at a clock edge. They load the winner of the inputs in the preceding cycle when `int_req` is 0 or `ack` is 1. They hold their values while `int_req` is 1 and `ack` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_req | input | 1 | Power-on/pin reset request |
| clkmon_req | input | 1 | Clock monitor reset request |
| wdog_req | input | 1 | Watchdog reset request |
| xirq_n | input | 1 | External non-maskable request, active low |
| trap_req | input | 1 | Unimplemented-opcode trap request |
| swi_req | input | 1 | Software interrupt request |
| irq_n | input | 1 | External maskable request pin, active low |
| periph_flag | input | NMASK-1 | Peripheral flag bits, bit k-1 for source k |
| periph_en | input | NMASK-1 | Peripheral enable bits, bit k-1 for source k |
| i_bit | input | 1 | Maskable mask bit |
| x_bit | input | 1 | `xirq_n` mask bit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: elevation byte, 1: pin mode |
| wr_data | input | 8 | Write data |
| ack | input | 1 | CPU takes the presented vector |
| int_req | output | 1 | Interrupt request to CPU |
| vec_lo | output | 8 | Vector low byte of the granted source |
| src_id | output | 6 | Identifier of the granted source |

## Verification
The bench sweeps every pair of maskable sources, both with no valid elevation and with each source elevated in turn. A design that ignored the elevation byte, or that decoded it to a neighbour, would pick the wrong member of some pair. All 64 combinations of the non-maskable requests are driven with and without a competing maskable source. This catches a trap or software interrupt placed above a maskable source, and it catches an `xirq_n` that is not gated by its mask. Targeted cases cover an elevation write while `i_bit` is clear, the unused low bit of that byte, a flag without its enable, and a hold that a reset request must not break. They also check that an edge is consumed on acknowledge while a level keeps requesting.

// File: rtl/intprio_pkg.sv
package intprio_pkg;

    localparam int NUM_NMI = 6;
    localparam int ID_W    = 6;

    typedef enum logic [2:0] {
        NMI_POR    = 3'd0,
        NMI_CLKMON = 3'd1,
        NMI_WDOG   = 3'd2,
        NMI_XPIN   = 3'd3,
        NMI_TRAP   = 3'd4,
        NMI_SWI    = 3'd5
    } nmi_e;

    typedef struct packed {
        logic            req;
        logic [7:0]      vec;
        logic [ID_W-1:0] id;
    } grant_t;

    function automatic logic [7:0] nmi_vec(input int unsigned idx);
        case (idx)
            0:       return 8'hFE;
            1:       return 8'hFC;
            2:       return 8'hFA;
            3:       return 8'hF4;
            4:       return 8'hF8;
            default: return 8'hF6;
        endcase
    endfunction

    function automatic logic [7:0] mask_vec(input int unsigned k, input logic [7:0] top);
        return top - 8'(2 * k);
    endfunction

endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect (
    input  logic clk,
    input  logic rst,
    input  logic irq_n,
    input  logic edge_mode,
    input  logic clear,
    output logic pending
);
    logic prev_q;
    logic held_q;
    logic fall;
    logic held_next;

    assign fall      = prev_q & ~irq_n;
    assign held_next = (held_q | fall) & ~clear;
    assign pending   = edge_mode ? held_next : ~irq_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            held_q <= 1'b0;
        end else begin
            prev_q <= irq_n;
            held_q <= edge_mode ? held_next : 1'b0;
        end
    end
endmodule

// File: rtl/prio_cfg_regs.sv
module prio_cfg_regs #(
    parameter logic [7:0] ELEV_RST = 8'hDE
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       i_bit,
    output logic [7:0] elev_q,
    output logic       edge_mode_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            elev_q      <= ELEV_RST;
            edge_mode_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_sel)
                edge_mode_q <= wr_data[0];
            else if (i_bit)
                elev_q <= {wr_data[7:1], 1'b0};
        end
    end
endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter
    import intprio_pkg::*;
#(
    parameter int         NMASK   = 16,
    parameter logic [7:0] VEC_TOP = 8'hF2
) (
    input  logic [NUM_NMI-1:0] nmi_req,
    input  logic [NMASK-1:0]   mreq,
    input  logic [7:0]         elev,
    output grant_t             grant
);
    logic [NMASK-1:0] hit;

    for (genvar k = 0; k < NMASK; k++) begin : g_hit
        assign hit[k] = (elev == mask_vec(k, VEC_TOP));
    end

    logic            m_found;
    logic [ID_W-1:0] m_win;
    logic [ID_W-1:0] e_idx;
    logic            e_valid;

    always_comb begin
        m_found = 1'b0;
        m_win   = '0;
        e_idx   = '0;
        e_valid = 1'b0;
        for (int k = NMASK - 1; k >= 0; k--) begin
            if (mreq[k]) begin
                m_found = 1'b1;
                m_win   = ID_W'(k);
            end
            if (hit[k] && mreq[k]) begin
                e_valid = 1'b1;
                e_idx   = ID_W'(k);
            end
        end
        if (e_valid)
            m_win = e_idx;
    end

    always_comb begin
        grant = '0;
        if (|nmi_req[3:0]) begin
            for (int i = 3; i >= 0; i--) begin
                if (nmi_req[i]) begin
                    grant.req = 1'b1;
                    grant.id  = ID_W'(i);
                    grant.vec = nmi_vec(i);
                end
            end
        end else if (m_found) begin
            grant.req = 1'b1;
            grant.id  = ID_W'(NUM_NMI) + m_win;
            grant.vec = VEC_TOP - {m_win[6:0], 1'b0};
        end else if (nmi_req[NMI_TRAP]) begin
            grant.req = 1'b1;
            grant.id  = ID_W'(NMI_TRAP);
            grant.vec = nmi_vec(NMI_TRAP);
        end else if (nmi_req[NMI_SWI]) begin
            grant.req = 1'b1;
            grant.id  = ID_W'(NMI_SWI);
            grant.vec = nmi_vec(NMI_SWI);
        end
    end
endmodule

// File: rtl/intprio_ctrl.sv
module intprio_ctrl
    import intprio_pkg::*;
#(
    parameter int         NMASK   = 16,
    parameter logic [7:0] VEC_TOP = 8'hF2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             por_req,
    input  logic             clkmon_req,
    input  logic             wdog_req,
    input  logic             xirq_n,
    input  logic             trap_req,
    input  logic             swi_req,
    input  logic             irq_n,
    input  logic [NMASK-2:0] periph_flag,
    input  logic [NMASK-2:0] periph_en,
    input  logic             i_bit,
    input  logic             x_bit,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             ack,
    output logic             int_req,
    output logic [7:0]       vec_lo,
    output logic [ID_W-1:0]  src_id
);
    localparam logic [ID_W-1:0] IRQ_ID = ID_W'(NUM_NMI);

    logic [7:0]         elev_q;
    logic               edge_mode_q;
    logic               irq_pend;
    logic               irq_clear;
    logic [NMASK-1:0]   mreq;
    logic [NUM_NMI-1:0] nmi_req;
    grant_t             grant_next;
    grant_t             grant_q;

    prio_cfg_regs u_cfg (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .i_bit       (i_bit),
        .elev_q      (elev_q),
        .edge_mode_q (edge_mode_q)
    );

    assign irq_clear = ack & grant_q.req & (grant_q.id == IRQ_ID);

    irq_pin_detect u_pin (
        .clk       (clk),
        .rst       (rst),
        .irq_n     (irq_n),
        .edge_mode (edge_mode_q),
        .clear     (irq_clear),
        .pending   (irq_pend)
    );

    assign mreq    = {periph_flag & periph_en, irq_pend} & {NMASK{~i_bit}};
    assign nmi_req = {swi_req, trap_req, ~xirq_n & ~x_bit, wdog_req, clkmon_req, por_req};

    prio_arbiter #(.NMASK(NMASK), .VEC_TOP(VEC_TOP)) u_arb (
        .nmi_req (nmi_req),
        .mreq    (mreq),
        .elev    (elev_q),
        .grant   (grant_next)
    );

    always_ff @(posedge clk) begin
        if (rst)
            grant_q <= '0;
        else if (!grant_q.req || ack)
            grant_q <= grant_next;
    end

    assign int_req = grant_q.req;
    assign vec_lo  = grant_q.vec;
    assign src_id  = grant_q.id;
endmodule

// File: rtl/intprio_ctrl_chk.sv
module intprio_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       por_req,
    input logic       clkmon_req,
    input logic       wdog_req,
    input logic       x_bit,
    input logic       i_bit,
    input logic       ack,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [7:0] elev,
    input logic       int_req,
    input logic [7:0] vec_lo,
    input logic [5:0] src_id
);
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        int_req && !ack |=> int_req && $stable(vec_lo) && $stable(src_id)); // R10

    AST_POR_FIRST: assert property (@(posedge clk) disable iff (rst)
        por_req && (!int_req || ack) |=> int_req && src_id == 6'd0 && vec_lo == 8'hFE); // R2

    AST_IMASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        i_bit && (!int_req || ack) |=> !int_req || src_id < 6'd6); // R3

    AST_XMASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        x_bit && !por_req && !clkmon_req && !wdog_req && (!int_req || ack)
        |=> !int_req || src_id != 6'd3); // R4

    AST_ELEV_LOCKED: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_sel && !i_bit |=> $stable(elev)); // R7
endmodule

bind intprio_ctrl intprio_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .por_req    (por_req),
    .clkmon_req (clkmon_req),
    .wdog_req   (wdog_req),
    .x_bit      (x_bit),
    .i_bit      (i_bit),
    .ack        (ack),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .elev       (elev_q),
    .int_req    (int_req),
    .vec_lo     (vec_lo),
    .src_id     (src_id)
);

// File: tb/sim_intprio_ctrl.sv
`timescale 1ns/1ps
module sim_intprio_ctrl;
    localparam int NM = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por_req = 0, clkmon_req = 0, wdog_req = 0, xirq_n = 1, trap_req = 0, swi_req = 0;
    logic irq_n = 1;
    logic [NM-2:0] periph_flag = '0, periph_en = '0;
    logic i_bit = 0, x_bit = 0, wr_en = 0, wr_sel = 0, ack = 1;
    logic [7:0] wr_data = '0;
    logic int_req;
    logic [7:0] vec_lo;
    logic [5:0] src_id;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    intprio_ctrl u0 (
        .clk(clk), .rst(rst), .por_req(por_req), .clkmon_req(clkmon_req), .wdog_req(wdog_req),
        .xirq_n(xirq_n), .trap_req(trap_req), .swi_req(swi_req), .irq_n(irq_n),
        .periph_flag(periph_flag), .periph_en(periph_en), .i_bit(i_bit), .x_bit(x_bit),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ack(ack),
        .int_req(int_req), .vec_lo(vec_lo), .src_id(src_id)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [14:0] exp);
        logic [14:0] act;
        act = {int_req, vec_lo, src_id};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act req=%0b vec=%02h id=%0d exp req=%0b vec=%02h id=%0d",
                     tag, act[14], act[13:6], act[5:0], exp[14], exp[13:6], exp[5:0]);
        end
    endtask

    function automatic logic [14:0] mgrant(input int k);
        return {1'b1, 8'(8'hF2 - 2 * k), 6'(6 + k)};
    endfunction

    function automatic logic [7:0] nvec(input int i);
        case (i)
            0: return 8'hFE; 1: return 8'hFC; 2: return 8'hFA;
            3: return 8'hF4; 4: return 8'hF8; default: return 8'hF6;
        endcase
    endfunction

    function automatic logic [14:0] model(input logic [5:0] n, input logic [NM-1:0] m, input int ek);
        for (int i = 0; i < 4; i++)
            if (n[i]) return {1'b1, nvec(i), 6'(i)};
        if (ek >= 0 && m[ek]) return mgrant(ek);
        for (int k = 0; k < NM; k++)
            if (m[k]) return mgrant(k);
        if (n[4]) return {1'b1, nvec(4), 6'd4};
        if (n[5]) return {1'b1, nvec(5), 6'd5};
        return '0;
    endfunction

    task automatic set_mask(input logic [NM-1:0] m);
        irq_n       = ~m[0];
        periph_flag = m[NM-1:1];
        periph_en   = m[NM-1:1];
    endtask

    task automatic write_elev(input logic [7:0] d, input logic ib);
        logic save;
        save = i_bit;
        i_bit = ib; wr_en = 1; wr_sel = 0; wr_data = d;
        step();
        wr_en = 0; i_bit = save;
    endtask

    task automatic write_mode(input logic d);
        wr_en = 1; wr_sel = 1; wr_data = {7'd0, d};
        step();
        wr_en = 0; wr_sel = 0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: act=timeout exp=completion");
        finish_run();
    end

    initial begin
        #1;
        step(); step();
        chk("R1 reset outputs", 15'd0);
        rst = 0;
        step();
        chk("R1 idle after reset", 15'd0);

        // R1 / R6: default elevation 0xDE lifts source 10 over source 1
        set_mask(16'h0402);
        step();
        chk("R1 default elevation", mgrant(10));
        set_mask('0);

        // R8: unmatched elevation byte
        write_elev(8'h01, 1'b1);

        // R3 single-source sweep
        for (int k = 0; k < NM; k++) begin
            set_mask(NM'(1) << k);
            step();
            chk($sformatf("R3 single k=%0d", k), mgrant(k));
        end
        set_mask('0);

        // R3: flag without enable
        periph_flag = 15'h0010;
        step();
        chk("R3 flag without enable", 15'd0);
        periph_flag = '0;

        // R3 / R8 pair sweep in default order
        for (int a = 0; a < NM; a++)
            for (int b = a + 1; b < NM; b++) begin
                set_mask((NM'(1) << a) | (NM'(1) << b));
                step();
                chk($sformatf("R8 pair %0d,%0d", a, b), mgrant(a));
            end
        set_mask('0);

        // R3: I bit masks all maskable sources
        i_bit = 1;
        set_mask(16'hFFFF);
        step();
        chk("R3 i_bit masks", 15'd0);
        set_mask('0);
        i_bit = 0;

        // R6 elevation sweep
        for (int e = 0; e < NM; e++) begin
            write_elev(8'(8'hF2 - 2 * e), 1'b1);
            for (int b = 0; b < NM; b++) begin
                if (b == e) continue;
                set_mask((NM'(1) << e) | (NM'(1) << b));
                step();
                chk($sformatf("R6 elev %0d vs %0d", e, b), mgrant(e));
            end
            set_mask('0);
        end

        // R7: write ignored while I clear
        write_elev(8'hEC, 1'b1);
        write_elev(8'hE8, 1'b0);
        set_mask(16'h0028);
        step();
        chk("R7 locked write ignored", mgrant(3));
        set_mask('0);

        // R7: bit 0 ignored, 0xE3 acts as 0xE2 (source 8)
        write_elev(8'hE3, 1'b1);
        set_mask(16'h0180);
        step();
        chk("R7 low bit ignored", mgrant(8));
        set_mask('0);

        // R2 / R4 / R5: all non-maskable combinations, with and without maskable 4
        write_elev(8'h00, 1'b1);
        for (int c = 0; c < 64; c++)
            for (int w = 0; w < 2; w++) begin
                logic [5:0] n;
                n = 6'(c);
                por_req = n[0]; clkmon_req = n[1]; wdog_req = n[2];
                xirq_n = ~n[3]; trap_req = n[4]; swi_req = n[5];
                set_mask(w ? 16'h0010 : 16'h0000);
                step();
                chk($sformatf("R2 R5 nmi=%02h m=%0d", c, w),
                    model(n, w ? 16'h0010 : 16'h0000, -1));
            end
        por_req = 0; clkmon_req = 0; wdog_req = 0; xirq_n = 1; trap_req = 0; swi_req = 0;
        set_mask('0);

        // R4: X bit masks the xirq_n pin
        x_bit = 1; xirq_n = 0;
        set_mask(16'h0004);
        step();
        chk("R4 x_bit masks pin", mgrant(2));
        x_bit = 0;
        step();
        chk("R4 pin beats maskable", {1'b1, 8'hF4, 6'd3});
        xirq_n = 1;
        set_mask('0);
        step();

        // R9 edge mode and R10 hold
        write_mode(1'b1);
        ack = 0;
        step();
        chk("R9 no edge yet", 15'd0);
        irq_n = 0;
        step();
        chk("R9 falling edge", mgrant(0));
        por_req = 1;
        step();
        chk("R10 hold without ack", mgrant(0));
        por_req = 0;
        i_bit = 1; ack = 1;
        step();
        chk("R10 reload on ack", 15'd0);
        ack = 0; i_bit = 0;
        step(); step();
        chk("R9 edge consumed", 15'd0);
        write_mode(1'b0);
        step();
        chk("R9 level mode requests", mgrant(0));
        irq_n = 1;
        step();
        chk("R10 held after pin release", mgrant(0));

        finish_run();
    end
endmodule